// File: doc/BRIEF.md
# Event Input Glitch Filter with Down Counter

This block takes an external event line, such as a mechanical contact or a slow sensor output. It turns each qualifying edge of that line into a single-cycle count strobe. It also keeps a down counter that drops by one on every strobe. The line first passes through a flop synchronizer into the system clock domain. The block divides a slow oscillator tick, given as a one-cycle enable at 32.768 kHz, by sixteen. This produces a 2,048 Hz sampling wave.

When the filter is switched on, a new line level is accepted only once it has persisted through two falling edges of the sampling wave. Chatter shorter than one sampling period is therefore discarded. Any pulse longer than two sampling periods always gets through. When the filter is off, the synchronized line feeds the edge detector directly. A polarity input chooses whether falling or rising edges of the resulting level are counted.

Top module: `event_noise_rejector`

## Requirements
- R1: While and right after reset, `cnt_strobe` is 0, `evt_count` equals the parameter `CNT_INIT`, and the accepted line level is `IDLE_LVL` (default 1).
- R2: With `rej_en` = 0, a change on `evt_pin` reaches the edge detector after the `SYNC_STAGES` synchronizer flops. With the default of 2, a qualifying change driven before clock edge k raises `cnt_strobe` in the cycle after edge k+1.
- R3: `edge_pol` = 0 counts falling edges (1 to 0) of the level that feeds the counter. `edge_pol` = 1 counts rising edges (0 to 1). The other edge direction produces no strobe.
- R4: Each counted edge gives a `cnt_strobe` pulse exactly one system-clock cycle wide.
- R5: Each strobe lowers `evt_count` by exactly one, wrapping modulo 2^`CNT_W`. Without a strobe, the count holds.
- R6: With `rej_en` = 1, a new synchronized level is accepted at the second sampling falling edge after it appears. The strobe is high in the cycle that follows that edge, and the accepted level changes at no other time.
- R7: With `rej_en` = 1, a high or low pulse lasting at least two sampling periods plus the synchronizer delay is always counted.
- R8: With `rej_en` = 1, a pulse shorter than one sampling period is never counted, wherever it falls relative to the sampling wave.
- R9: With `rej_en` = 1, if the line returns to the accepted level before confirmation, the pending change is dropped and its edge tally clears. A later change needs two fresh sampling falling edges.
- R10: The sampling falling edge occurs on every 2^`DIV_LOG2`-th `osc_tick` (default 16th) counted from reset, on the 16th, 32nd, and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle enable at the 32.768 kHz oscillator rate |
| evt_pin | input | 1 | Raw external event line (asynchronous) |
| rej_en | input | 1 | 1 enables the glitch filter, 0 bypasses it |
| edge_pol | input | 1 | Counted edge: 0 falling, 1 rising |
| cnt_strobe | output | 1 | One-cycle pulse per counted edge |
| evt_count | output | CNT_W | Down counter value |

## Verification
Suppose the edge tally fails to clear when the line returns. The fault then shows up at the next sampling falling edge after a second short excursion, as an extra strobe and an extra decrement. Suppose instead the divider phase or the confirmation depth is wrong. The strobe then moves by a whole sampling period, 128 system cycles at the bench tick rate. Tests aligned to the divider phase see this as a strobe one sampling edge early or late. A wrong edge select or a stuck strobe is visible within three cycles in bypass mode, as a wrong count value.

// File: rtl/enr_pkg.sv
package enr_pkg;
   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_sel_e;
endpackage

// File: rtl/enr_tick_div.sv
module enr_tick_div #(
   parameter int DIV_LOG2 = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_tick,
   output logic samp_fall
);
   logic [DIV_LOG2-1:0] div_q;

   generate
      if (DIV_LOG2 < 1) begin : g_bad_div
         $error("enr_tick_div: DIV_LOG2 must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_q <= '0;
      else if (osc_tick) div_q <= div_q + 1'b1;
   end

   // the sampling wave is div_q's MSB; it falls when the divider wraps
   assign samp_fall = osc_tick & (&div_q);
endmodule

// File: rtl/enr_sync.sv
module enr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("enr_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stg
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/enr_level_filter.sv
module enr_level_filter #(
   parameter int   CONFIRM = 2,
   parameter logic RST_VAL = 1'b1,
   localparam int  HW      = $clog2(CONFIRM + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          lvl_in,
   input  logic          samp_fall,
   output logic          acc_lvl,
   output logic [HW-1:0] hits
);
   generate
      if (CONFIRM < 1) begin : g_bad_confirm
         $error("enr_level_filter: CONFIRM must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_lvl <= RST_VAL;
         hits    <= '0;
      end else if (!en) begin
         // track the line so enabling the filter never makes a false edge
         acc_lvl <= lvl_in;
         hits    <= '0;
      end else if (lvl_in == acc_lvl) begin
         hits    <= '0;
      end else if (samp_fall) begin
         if (hits == HW'(CONFIRM - 1)) begin
            acc_lvl <= lvl_in;
            hits    <= '0;
         end else begin
            hits    <= hits + 1'b1;
         end
      end
   end
endmodule

// File: rtl/enr_edge_count.sv
module enr_edge_count
   import enr_pkg::*;
#(
   parameter int             CNT_W    = 8,
   parameter logic [CNT_W-1:0] CNT_INIT = '1,
   parameter logic           RST_LVL  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl,
   input  edge_sel_e        pol,
   output logic             strobe,
   output logic [CNT_W-1:0] count
);
   logic prev_q;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("enr_edge_count: CNT_W must be at least 1");
      end
   endgenerate

   always_comb begin
      if (pol == EDGE_FALL) strobe = prev_q & ~lvl;
      else                  strobe = ~prev_q & lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= RST_LVL;
         count  <= CNT_INIT;
      end else begin
         prev_q <= lvl;
         if (strobe) count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/event_noise_rejector.sv
module event_noise_rejector
   import enr_pkg::*;
#(
   parameter int               CNT_W       = 8,
   parameter logic [CNT_W-1:0] CNT_INIT    = '1,
   parameter int               SYNC_STAGES = 2,
   parameter int               DIV_LOG2    = 4,
   parameter int               CONFIRM     = 2,
   parameter logic             IDLE_LVL    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             osc_tick,
   input  logic             evt_pin,
   input  logic             rej_en,
   input  logic             edge_pol,
   output logic             cnt_strobe,
   output logic [CNT_W-1:0] evt_count
);
   localparam int HW = $clog2(CONFIRM + 1);

   logic          pin_s;
   logic          samp_fall;
   logic          acc_lvl;
   logic          cnt_lvl;
   logic [HW-1:0] hit_cnt;

   enr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(evt_pin), .q(pin_s)
   );

   enr_tick_div #(.DIV_LOG2(DIV_LOG2)) u_div (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .samp_fall(samp_fall)
   );

   enr_level_filter #(.CONFIRM(CONFIRM), .RST_VAL(IDLE_LVL)) u_filt (
      .clk(clk), .rst_n(rst_n), .en(rej_en), .lvl_in(pin_s),
      .samp_fall(samp_fall), .acc_lvl(acc_lvl), .hits(hit_cnt)
   );

   assign cnt_lvl = rej_en ? acc_lvl : pin_s;

   enr_edge_count #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT), .RST_LVL(IDLE_LVL)) u_cnt (
      .clk(clk), .rst_n(rst_n), .lvl(cnt_lvl), .pol(edge_sel_e'(edge_pol)),
      .strobe(cnt_strobe), .count(evt_count)
   );
endmodule

// File: rtl/enr_checker.sv
module enr_checker #(
   parameter int CNT_W   = 8,
   parameter int HW      = 2,
   parameter int CONFIRM = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             samp_fall,
   input logic             acc,
   input logic [HW-1:0]    hits,
   input logic             strobe,
   input logic [CNT_W-1:0] count
);
   // R4: strobe never lasts two cycles
   assert_one_cycle_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);

   // R5: a strobe takes exactly one off the count
   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> (count == CNT_W'($past(count) - 1'b1)));

   // R5: no strobe, no change
   assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(count));

   // R6: with the filter on, the accepted level moves only on a sampling falling edge
   assert_accept_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !samp_fall) |=> $stable(acc));

   // R9: the pending tally never reaches the confirmation depth
   assert_hits_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hits < HW'(CONFIRM));
endmodule

bind event_noise_rejector enr_checker #(.CNT_W(CNT_W), .HW(HW), .CONFIRM(CONFIRM)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(rej_en), .samp_fall(samp_fall), .acc(acc_lvl),
   .hits(hit_cnt), .strobe(cnt_strobe), .count(evt_count)
);

// File: tb/event_noise_rejector_tb.sv
module event_noise_rejector_tb;
   localparam int P = 128;   // sampling period in system cycles (osc_tick every 8)

   logic clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0;
   logic evt_pin = 1'b1, rej_en = 1'b0, edge_pol = 1'b0;
   logic       cnt_strobe;
   logic [7:0] evt_count;

   int n_run = 0, n_fail = 0, strb_tot = 0, ph = 0, nt = 0;
   logic [7:0] exp_cnt = 8'd2;
   bit done = 0;
   event fall_ev;

   always #10 clk = ~clk;

   event_noise_rejector #(.CNT_W(8), .CNT_INIT(8'd2)) u_dut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .evt_pin(evt_pin),
      .rej_en(rej_en), .edge_pol(edge_pol), .cnt_strobe(cnt_strobe), .evt_count(evt_count)
   );

   always @(posedge clk) if (rst_n && cnt_strobe) strb_tot <= strb_tot + 1;

   always @(negedge clk) begin
      if (!rst_n) begin ph = 0; osc_tick = 1'b0; end
      else begin ph = (ph + 1) % 8; osc_tick = (ph == 0); end
   end

   // R10 model: every 16th consumed tick is a sampling falling edge
   always @(posedge clk) begin
      if (!rst_n) nt = 0;
      else if (osc_tick) begin
         if (nt == 15) -> fall_ev;
         nt = (nt + 1) % 16;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_fall();
      @(fall_ev);
      @(negedge clk);
   endtask

   task automatic t_reset();
      cyc(3);
      chk("R1", "strobe in reset", cnt_strobe, 0);
      chk("R1", "count in reset", evt_count, 2);
      rst_n = 1'b1;
      cyc(4);
      chk("R1", "strobe after reset", cnt_strobe, 0);
      chk("R1", "count after reset", evt_count, 2);
   endtask

   task automatic t_bypass_fall();
      int base = strb_tot;
      rej_en = 1'b0; edge_pol = 1'b0;
      evt_pin = 1'b0;
      cyc(1); chk("R2", "strobe after one edge", cnt_strobe, 0);
      cyc(1); chk("R2", "strobe after two edges", cnt_strobe, 1);
      cyc(1); chk("R4", "strobe width", cnt_strobe, 0);
      exp_cnt = exp_cnt - 8'd1;
      chk("R5", "count after fall", evt_count, exp_cnt);
      evt_pin = 1'b1; cyc(5);
      evt_pin = 1'b0; cyc(5);
      evt_pin = 1'b1; cyc(5);
      exp_cnt = exp_cnt - 8'd1;
      chk("R3", "falling edges counted", strb_tot - base, 2);
      chk("R5", "count after bypass", evt_count, exp_cnt);
   endtask

   task automatic t_bypass_rise();
      int base = strb_tot;
      edge_pol = 1'b1; cyc(3);
      chk("R3", "polarity switch alone", strb_tot - base, 0);
      evt_pin = 1'b0; cyc(5);
      chk("R3", "falling ignored with pol 1", strb_tot - base, 0);
      evt_pin = 1'b1; cyc(5);
      exp_cnt = exp_cnt - 8'd1;
      chk("R3", "rising counted with pol 1", strb_tot - base, 1);
      chk("R5", "count wraps", evt_count, exp_cnt);
      edge_pol = 1'b0; cyc(3);
   endtask

   task automatic t_confirm();
      int base;
      rej_en = 1'b1; cyc(3);
      base = strb_tot;
      wait_fall();
      evt_pin = 1'b0;
      wait_fall();
      chk("R6", "strobe at first sampling edge", cnt_strobe, 0);
      chk("R6", "no count at first edge", strb_tot - base, 0);
      wait_fall();
      chk("R6", "strobe at second sampling edge", cnt_strobe, 1);
      cyc(1);
      chk("R4", "filtered strobe width", cnt_strobe, 0);
      exp_cnt = exp_cnt - 8'd1;
      chk("R6", "count after confirm", evt_count, exp_cnt);
      evt_pin = 1'b1;
      wait_fall(); wait_fall(); wait_fall();
      chk("R10", "rising not counted, single strobe", strb_tot - base, 1);
   endtask

   task automatic t_long();
      int base = strb_tot;
      for (int k = 0; k < 2; k++) begin
         evt_pin = 1'b0; cyc(2 * P + 10);
         evt_pin = 1'b1; cyc(2 * P + 10);
      end
      exp_cnt = exp_cnt - 8'd2;
      chk("R7", "long pulses counted", strb_tot - base, 2);
      chk("R7", "count after long pulses", evt_count, exp_cnt);
   endtask

   task automatic t_short();
      int base = strb_tot;
      for (int k = 0; k < 4; k++) begin
         evt_pin = 1'b0; cyc(P - 13);
         evt_pin = 1'b1; cyc(150 + 17 * k);
      end
      chk("R8", "short low glitches rejected", strb_tot - base, 0);
      chk("R8", "count after glitches", evt_count, exp_cnt);
      evt_pin = 1'b0; cyc(2 * P + 10);
      evt_pin = 1'b1; cyc(2 * P + 10);
      exp_cnt = exp_cnt - 8'd1;
      chk("R8", "accepted level kept high", strb_tot - base, 1);
   endtask

   task automatic t_cancel();
      int base = strb_tot;
      wait_fall();
      evt_pin = 1'b0;
      wait_fall();
      cyc(64);
      evt_pin = 1'b1;
      cyc(30);
      evt_pin = 1'b0;
      wait_fall();
      chk("R9", "no strobe after restart", cnt_strobe, 0);
      chk("R9", "tally cleared on return", strb_tot - base, 0);
      cyc(20);
      evt_pin = 1'b1;
      cyc(3 * P);
      chk("R9", "cancelled changes uncounted", strb_tot - base, 0);
      chk("R9", "count unchanged", evt_count, exp_cnt);
   endtask

   initial begin
      t_reset();
      t_bypass_fall();
      t_bypass_rise();
      t_confirm();
      t_long();
      t_short();
      t_cancel();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule